// File: doc/BRIEF.md
# Presettable Down Counter with Zero Decode

This block is a programmable down counter used to divide a slow external count clock by a chosen value N. It runs entirely on a fast system clock. The external count clock and the inhibit line are synchronised and edge-detected inside the block. A count step happens on a rising edge of the count clock while inhibit is low. It also happens on a falling edge of inhibit while the count clock is high, so inhibit can act as a second clock of opposite polarity.

A preset-enable input loads preset data into the counter. The load takes effect on the next system clock and overrides any count step. The release of preset enable passes through a synchroniser, and count steps are held off until that release has been seen. A decoded zero flag is high when the count is zero and the chain-enable input is high. Feeding the zero flag back to preset enable turns one stage into a divide-by-N. Several stages can be chained through their chain-enable inputs to build wider dividers.

Top module: `divn_down_counter`

## Requirements
- R1: After a synchronous reset (rst_ni low on a rising system clock edge) the count is 0.
- R2: A rising edge on cnt_clk_i while hold_i is low decrements the count by exactly one.
- R3: A falling edge on hold_i while cnt_clk_i is high decrements the count by exactly one.
- R4: While hold_i is high, rising edges on cnt_clk_i leave the count unchanged, and without a count step or a load the count never changes.
- R5: While load_i is high the count takes load_val_i on the next system clock, whatever the count clock does. No count step is taken until the synchronised release of load_i, two system clocks after load_i falls.
- R6: zero_o is high when the count equals 0 and chain_i is high.
- R7: zero_o is low whenever chain_i is low.
- R8: A count step from 0 wraps the 4-bit count to 15.
- R9: With zero_o wired to load_i, chain_i high and preset N > 0, zero_o gives exactly one rising edge per N count steps, and the count is back at N after each zero.
- R10: With zero_o wired to load_i, chain_i high and preset 0, the count stays 0 and zero_o stays high through count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than cnt_clk_i |
| rst_ni | input | 1 | Synchronous active-low reset |
| cnt_clk_i | input | 1 | External count clock, counts on its rising edge |
| hold_i | input | 1 | Inhibit; its falling edge counts when cnt_clk_i is high |
| load_i | input | 1 | Preset enable, loads load_val_i |
| load_val_i | input | CNT_W | Preset data |
| chain_i | input | 1 | Chain enable that qualifies the zero flag |
| count_o | output | CNT_W | Current count value |
| zero_o | output | 1 | Decoded zero flag |

## Verification
The checks assume that cnt_clk_i and hold_i change slowly compared with the system clock. Each level is held for several system clocks, the two lines never switch in the same cycle, and both are low while reset is applied, so no spurious edge appears when the synchronisers come out of reset. The stimulus changes one input at a time and then waits six system clocks before the next change. Load pulses are kept apart from count edges by the same spacing, so every count step lands outside the load-release window.

// File: rtl/divn_pkg.sv
// Package: shared operation codes and arithmetic for the down-counter block.
// Assumes: counter width is supplied by the users of these helpers.
package divn_pkg;

    // Next-state operation selected by the counter core each system clock.
    typedef enum logic [1:0] {
        CORE_HOLD = 2'b00,
        CORE_STEP = 2'b01,
        CORE_LOAD = 2'b10
    } core_op_e;

    // Pick the core operation; a load always wins over a count step.
    function automatic core_op_e pick_op(input logic load_act, input logic step);
        if (load_act) begin
            return CORE_LOAD;
        end else if (step) begin
            return CORE_STEP;
        end
        return CORE_HOLD;
    endfunction

endpackage

// File: rtl/divn_sync.sv
// Module: multi-stage level synchroniser onto the system clock.
// Assumes: STAGES >= 2; input is a slowly changing level.
module divn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/divn_event_det.sv
// Module: turns synchronised count-clock and inhibit levels into a one-cycle
// count-step pulse. A rising count clock with inhibit low, or a falling
// inhibit with count clock high, each give one step.
// Assumes: inputs are already synchronised to clk_i.
module divn_event_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ck_s_i,
    input  logic hold_s_i,
    output logic step_o
);

    logic ck_d;
    logic hold_d;
    logic ck_rise;
    logic hold_fall;

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ck_d   <= 1'b0;
            hold_d <= 1'b0;
        end else begin
            ck_d   <= ck_s_i;
            hold_d <= hold_s_i;
        end
    end

    // Qualify each edge with the level of the other line.
    always_comb begin
        ck_rise   = ck_s_i & ~ck_d & ~hold_s_i;
        hold_fall = ~hold_s_i & hold_d & ck_s_i;
        step_o    = ck_rise | hold_fall;
    end

endmodule

// File: rtl/divn_count_core.sv
// Module: down-counting register with preset; wraps from zero to all ones.
// Assumes: load_i has priority over step_i.
module divn_count_core
    import divn_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    core_op_e         op;

    // Choose the next count from the selected operation.
    always_comb begin
        op = pick_op(load_i, step_i);
        case (op)
            CORE_LOAD: count_d = load_val_i;
            CORE_STEP: count_d = count_q - ONE;
            default:   count_d = count_q;
        endcase
    end

    // Hold the count value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/divn_down_counter.sv
// Module: presettable down counter with decoded, chain-qualified zero flag.
// Assumes: cnt_clk_i and hold_i are slow against clk_i and low during reset;
// the zero flag may be wired straight to load_i for divide-by-N.
module divn_down_counter #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_clk_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             chain_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    logic ck_s;
    logic hold_s;
    logic load_hold;
    logic step;
    logic load_act;

    divn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cnt_clk_i),
        .q_o   (ck_s)
    );

    divn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hold_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (hold_i),
        .q_o   (hold_s)
    );

    divn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_load_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (load_i),
        .q_o   (load_hold)
    );

    divn_event_det u_evt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ck_s_i  (ck_s),
        .hold_s_i(hold_s),
        .step_o  (step)
    );

    // Load acts at once on assertion and lasts until the release is synchronised.
    assign load_act = load_i | load_hold;

    divn_count_core #(.CNT_W(CNT_W)) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .load_i    (load_act),
        .load_val_i(load_val_i),
        .count_o   (count_o)
    );

    // Decode zero, qualified by the chain input.
    assign zero_o = chain_i & (count_o == '0);

endmodule

// File: rtl/divn_down_counter_chk.sv
// Module: property checker for divn_down_counter, attached with bind.
// Assumes: step and load_hold are the block's internal step pulse and
// synchronised load release.
module divn_down_counter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             step,
    input logic             load_i,
    input logic             load_hold,
    input logic [CNT_W-1:0] load_val_i,
    input logic             chain_i,
    input logic [CNT_W-1:0] count_o,
    input logic             zero_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && !load_i && !load_hold && count_o != '0) |=> count_o == $past(count_o) - ONE);

    assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && !load_i && !load_hold && count_o == '0) |=> count_o == TOP);

    assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step && !load_i && !load_hold) |=> $stable(count_o));

    assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> count_o == $past(load_val_i));

    assert_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chain_i |-> !zero_o);

endmodule

bind divn_down_counter divn_down_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step      (step),
    .load_i    (load_i),
    .load_hold (load_hold),
    .load_val_i(load_val_i),
    .chain_i   (chain_i),
    .count_o   (count_o),
    .zero_o    (zero_o)
);

// File: tb/divn_down_counter_tb_top.sv
`timescale 1ns/1ps
module divn_down_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_clk;
    logic       hold;
    logic       load_drv;
    logic       fb_mode;
    logic       load;
    logic [3:0] load_val;
    logic       chain;
    logic [3:0] count;
    logic       zero;

    int         n_checks = 0;
    int         n_fails  = 0;
    int         pulses   = 0;
    logic       zero_prev = 1'b0;
    logic [3:0] exp_cnt  = 4'd0;
    logic [3:0] fb_n     = 4'd0;

    always #2.5 clk = ~clk;

    assign load = fb_mode ? (zero | load_drv) : load_drv;

    divn_down_counter dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cnt_clk_i (cnt_clk),
        .hold_i    (hold),
        .load_i    (load),
        .load_val_i(load_val),
        .chain_i   (chain),
        .count_o   (count),
        .zero_o    (zero)
    );

    // Count rising edges of the zero flag, sampled between clock edges.
    always @(negedge clk) begin
        if (zero && !zero_prev) pulses++;
        zero_prev <= zero;
    end

    function automatic logic [3:0] dec4(input logic [3:0] v);
        return v - 4'd1;
    endfunction

    function automatic logic zero_exp(input logic [3:0] v, input logic ch);
        return ch && (v == 4'd0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, count, exp_cnt);
        chk(tag, zero, zero_exp(exp_cnt, chain));
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic set_clk(input logic v);
        if (!cnt_clk && v && !hold) exp_cnt = dec4(exp_cnt);
        cnt_clk = v;
        settle();
    endtask

    task automatic set_hold(input logic v);
        if (hold && !v && cnt_clk) exp_cnt = dec4(exp_cnt);
        hold = v;
        settle();
    endtask

    task automatic do_load(input logic [3:0] v);
        load_val = v;
        load_drv = 1'b1;
        repeat (3) @(negedge clk);
        load_drv = 1'b0;
        exp_cnt  = v;
        settle();
    endtask

    // One full count-clock pulse in feedback mode, with the reload modelled.
    task automatic fb_pulse();
        cnt_clk = 1'b1;
        settle();
        exp_cnt = (exp_cnt <= 4'd1) ? fb_n : dec4(exp_cnt);
        cnt_clk = 1'b0;
        settle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cnt_clk = 1'b0; hold = 1'b0; load_drv = 1'b0;
        fb_mode = 1'b0; load_val = 4'd0; chain = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", count, 0);
        chk("R6 zero after reset", zero, 1);

        do_load(4'd5);
        chk_state("R5 load 5");
        set_clk(1'b1);
        chk_state("R2 rise counts");
        set_clk(1'b0);
        set_hold(1'b1);
        set_clk(1'b1);
        chk_state("R4 rise ignored while held");
        set_hold(1'b0);
        chk_state("R3 hold fall counts");
        set_clk(1'b0);

        // Load overrides a count edge arriving while it is asserted.
        load_val = 4'd9;
        load_drv = 1'b1;
        cnt_clk  = 1'b1;
        settle();
        load_drv = 1'b0;
        exp_cnt  = 4'd9;
        settle();
        chk_state("R5 load beats edge");
        set_clk(1'b0);

        do_load(4'd0);
        chk_state("R6 zero at count 0");
        chain = 1'b0;
        settle();
        chk("R7 chain low masks zero", zero, 0);
        chain = 1'b1;
        set_clk(1'b1);
        chk_state("R8 wrap to 15");
        set_clk(1'b0);

        // Divide-by-N through feedback.
        fb_n = 4'd5;
        load_val = fb_n;
        fb_mode = 1'b1;
        do_load(fb_n);
        pulses = 0;
        for (int i = 0; i < 10; i++) fb_pulse();
        chk("R9 zero pulses per 10 steps", pulses, 2);
        chk("R9 count back at N", count, fb_n);

        fb_n = 4'd3;
        load_val = fb_n;
        do_load(fb_n);
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            fb_pulse();
            chk("R9 count track", count, exp_cnt);
        end
        chk("R9 zero pulses per 9 steps", pulses, 3);

        fb_n = 4'd0;
        load_val = 4'd0;
        do_load(4'd0);
        for (int i = 0; i < 4; i++) begin
            fb_pulse();
            chk("R10 zero held", zero, 1);
            chk("R10 count held", count, 0);
        end
        fb_mode = 1'b0;
        settle();

        // Random phase: one input change per step.
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 5))
                0, 1:    set_clk(~cnt_clk);
                2, 3:    set_hold(~hold);
                4:       do_load(4'($urandom_range(0, 15)));
                default: begin chain = ~chain; settle(); end
            endcase
            chk_state("R2 R3 R4 R6 R7 R8 random");
        end

        finish_run();
    end

endmodule